// File: doc/BRIEF.md
# MDIO Clause 45 Mailbox Master

This block is a register-mapped management master for an external PHY. A host bus loads a 16-bit register address and a 16-bit write value into two words of a small mailbox, then writes a command word. The command names the frame type, the PHY port and the device number, and carries a self-clearing start bit. When a start is accepted, the block raises a busy flag and shifts one Clause 45 management frame out on the MDC/MDIO pair. Read frames return their 16-bit result in a read-data word, which is updated before busy drops.

Software accesses a PHY register in two steps. An address frame loads the register pointer in the selected device. A read or write frame then moves the data. Before each step, software polls busy until it clears. The command op-mode field uses a mailbox code, and the serializer translates it into the on-wire opcode. MDC is the system clock divided by an even parameter. MDIO changes only while MDC is low and is sampled as MDC rises.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, every mailbox word reads 0, MDC is low and the MDIO output enable is low.
- R2: Mailbox words at byte address BASE+0x4 (command), BASE+0x8 (write value), BASE+0xC (register address) and BASE+0x10 (read result), with BASE defaulting to 0x280. The write-value and register-address words keep bits 15:0 only and read back zero above bit 15. Other addresses read 0.
- R3: Command word fields are as follows. Bit 15 starts a frame when written as 1 and always reads 0. Bits 13:12 are the op mode. Bits 9:5 are the PHY port. Bits 4:0 are the device number. Bit 31 is the read-only busy flag. All other bits read 0.
- R4: Busy reads 1 on the cycle after an accepted start and stays 1 until the frame has ended.
- R5: A command write made while busy is 1 is ignored completely, and so is a start with op mode 0. Neither changes any field, and neither launches a frame.
- R6: Every frame is 64 bits, sent MSB first, in this order: 32 ones, start bits 00, a 2-bit opcode, the 5-bit port, the 5-bit device, 2 turnaround bits and 16 data bits.
- R7: Op mode 3 sends opcode 00 with the register-address word as data. Op mode 2 sends opcode 01 with the write-value word as data. For both, the master drives the turnaround bits as 1 then 0.
- R8: Op mode 1 sends opcode 11. The master releases MDIO (output enable low) for the turnaround and data bits. It samples the 16 data bits MSB first on MDC rising edges and writes them to the read-result word on the same clock edge on which busy clears.
- R9: MDC has a period of CLK_DIV system clocks with an equal high and low time, and stays low while idle. MDIO and its output enable never change while MDC is high.
- R10: A read addressed to a port that no PHY answers returns 0xFFFF, because the line is pulled up.
- R11: The MDIO output enable is low whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe |
| bus_addr_i | input | ADDR_W | Host byte address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data, combinational on bus_addr_i |
| mdc_o | output | 1 | Management clock to PHY |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The serializer holds several pieces of internal state: its bit index, its shift register and its busy flag. An error in any of them appears on the wire within the same frame. The symptom is a misplaced or missing opcode, turnaround or data bit, a frame that is not 64 MDC periods long, or busy that never clears. The bench captures every frame bit by bit on MDC rising edges and compares the complete 64-bit word against a value built from the command it issued. A wrong op-mode translation or a wrong word selection therefore fails on the first frame of that type. Read-capture errors appear in the read-result word as soon as busy drops.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  typedef enum logic [1:0] {
    OPM_NONE  = 2'd0,
    OPM_READ  = 2'd1,
    OPM_WRITE = 2'd2,
    OPM_ADDR  = 2'd3
  } opm_e;

  localparam int unsigned PORT_W = 5;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned VAL_W  = 16;

  typedef struct packed {
    opm_e              op;
    logic [PORT_W-1:0] port;
    logic [DEV_W-1:0]  dev;
  } cmd_t;

  // mailbox op mode -> clause 45 wire opcode
  function automatic logic [1:0] wire_op(opm_e m);
    logic [1:0] r;
    unique case (m)
      OPM_ADDR:  r = 2'b00;
      OPM_WRITE: r = 2'b01;
      default:   r = 2'b11;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned CLK_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_W'(HALF - 1));
  assign rise_o = run_i && wrap && !mdc_q;
  assign fall_o = run_i && wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [PRE_LEN+32-1:0]    frame_i,
  input  logic                     rd_i,
  input  logic                     rise_i,
  input  logic                     fall_i,
  input  logic                     mdio_i,
  output logic                     mdio_o,
  output logic                     mdio_oe_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [15:0]              cap_o
);
  localparam int unsigned FRAME_W = PRE_LEN + 32;
  localparam int unsigned TA_IDX  = PRE_LEN + 14;
  localparam int unsigned DAT_IDX = PRE_LEN + 16;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  logic               busy_q, rd_q, oe_q, out_q;
  logic [IDX_W-1:0]   idx_q, idx_nxt;
  logic [FRAME_W-1:0] sh_q;
  logic [15:0]        cap_q;
  logic               last;

  assign idx_nxt   = idx_q + 1'b1;
  assign last      = (idx_q == IDX_W'(FRAME_W - 1));
  assign done_o    = busy_q && fall_i && last;
  assign busy_o    = busy_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      out_q  <= 1'b1;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      idx_q  <= '0;
      sh_q   <= frame_i;
      out_q  <= frame_i[FRAME_W-1];
      oe_q   <= 1'b1;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DAT_IDX)))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          out_q  <= 1'b1;
        end else begin
          idx_q  <= idx_nxt;
          sh_q   <= sh_q << 1;
          out_q  <= sh_q[FRAME_W-2];
          // release line from the first turnaround bit of a read
          oe_q   <= !(rd_q && (idx_nxt >= IDX_W'(TA_IDX)));
        end
      end
    end
  end

endmodule

// File: rtl/mdio_mbox_regs.sv
module mdio_mbox_regs
  import mdio_c45_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h280
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [15:0]       cap_i,
  output logic              start_o,
  output cmd_t              start_cmd_o,
  output cmd_t              cmd_o,
  output logic [15:0]       reg_addr_o,
  output logic [15:0]       wr_val_o,
  output logic [15:0]       rd_val_o
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(BASE_ADDR + 4);
  localparam logic [ADDR_W-1:0] A_WVAL  = ADDR_W'(BASE_ADDR + 8);
  localparam logic [ADDR_W-1:0] A_RADDR = ADDR_W'(BASE_ADDR + 12);
  localparam logic [ADDR_W-1:0] A_RVAL  = ADDR_W'(BASE_ADDR + 16);

  cmd_t        cmd_q, wcmd;
  logic [15:0] raddr_q, wval_q, rval_q;
  logic        cmd_wr_ok;
  logic        unused_bits;

  assign wcmd = '{op: opm_e'(bus_wdata_i[13:12]),
                  port: bus_wdata_i[9:5],
                  dev: bus_wdata_i[4:0]};
  assign unused_bits = ^{bus_wdata_i[31:16], bus_wdata_i[14], bus_wdata_i[11:10]};

  assign cmd_wr_ok   = bus_we_i && (bus_addr_i == A_CMD) && !busy_i;
  assign start_o     = cmd_wr_ok && bus_wdata_i[15] && (wcmd.op != OPM_NONE);
  assign start_cmd_o = wcmd;
  assign cmd_o       = cmd_q;
  assign reg_addr_o  = raddr_q;
  assign wr_val_o    = wval_q;
  assign rd_val_o    = rval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '{op: OPM_NONE, port: '0, dev: '0};
      raddr_q <= '0;
      wval_q  <= '0;
      rval_q  <= '0;
    end else begin
      if (cmd_wr_ok && (wcmd.op != OPM_NONE || !bus_wdata_i[15]))
        cmd_q <= wcmd;
      if (bus_we_i && bus_addr_i == A_RADDR) raddr_q <= bus_wdata_i[15:0];
      if (bus_we_i && bus_addr_i == A_WVAL)  wval_q  <= bus_wdata_i[15:0];
      if (done_i && cmd_q.op == OPM_READ)    rval_q  <= cap_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CMD:   bus_rdata_o = {busy_i, 17'b0, cmd_q.op, 2'b0, cmd_q.port, cmd_q.dev};
      A_WVAL:  bus_rdata_o = {16'b0, wval_q};
      A_RADDR: bus_rdata_o = {16'b0, raddr_q};
      A_RVAL:  bus_rdata_o = {16'b0, rval_q};
      default: bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 100,
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h280
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned FRAME_W = PRE_LEN + 32;

  logic               busy_w, done_w, start_w, rise_w, fall_w;
  logic [15:0]        cap_w, reg_addr_w, wr_val_w, rd_data_w;
  cmd_t               scmd_w, cmd_w;
  logic [FRAME_W-1:0] frame_w;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b00, wire_op(scmd_w.op), scmd_w.port, scmd_w.dev,
                    2'b10, (scmd_w.op == OPM_WRITE) ? wr_val_w : reg_addr_w};

  mdio_mbox_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .busy_i(busy_w), .done_i(done_w), .cap_i(cap_w),
    .start_o(start_w), .start_cmd_o(scmd_w), .cmd_o(cmd_w),
    .reg_addr_o(reg_addr_w), .wr_val_o(wr_val_w), .rd_val_o(rd_data_w)
  );

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy_w), .mdc_o, .rise_o(rise_w), .fall_o(fall_w)
  );

  mdio_frame_shift #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk_i, .rst_ni, .start_i(start_w), .frame_i(frame_w),
    .rd_i(scmd_w.op == OPM_READ), .rise_i(rise_w), .fall_i(fall_w),
    .mdio_i, .mdio_o, .mdio_oe_o, .busy_o(busy_w), .done_o(done_w), .cap_o(cap_w)
  );

endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h280
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              busy_i,
  input logic              mdc_i,
  input logic              mdio_out_i,
  input logic              mdio_oe_i,
  input logic [1:0]        cmd_op_i,
  input logic [15:0]       rd_data_i
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BASE_ADDR + 4);

  logic cmd_wr;
  assign cmd_wr = bus_we_i && (bus_addr_i == A_CMD);

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && bus_wdata_i[15] && bus_wdata_i[13:12] != 2'd0) |=> busy_i); // R4
  AST_CMD_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> $stable(cmd_op_i)); // R5
  AST_NO_START_OPM0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && bus_wdata_i[13:12] == 2'd0) |=> !busy_i); // R5
  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i); // R9
  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i |-> ($stable(mdio_out_i) && $stable(mdio_oe_i))); // R9
  AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdio_oe_i); // R11
  AST_RDATA_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_i) |-> $fell(busy_i)); // R8

endmodule

bind mdio_c45_master mdio_c45_master_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .busy_i(busy_w), .mdc_i(mdc_o), .mdio_out_i(mdio_o),
  .mdio_oe_i(mdio_oe_o), .cmd_op_i(cmd_w.op), .rd_data_i(rd_data_w)
);

// File: tb/tb_mdio_c45_master.sv
`timescale 1ns/1ps
module tb_mdio_c45_master;
  localparam int DIV = 8;
  localparam logic [4:0] PHY_PORT = 5'd9;
  localparam logic [11:0] A_CMD = 12'h284, A_WVAL = 12'h288, A_RADDR = 12'h28C, A_RVAL = 12'h290;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc_o, mdio_o, mdio_oe, mdio_line;
  logic        phy_en = 1'b0, phy_bit = 1'b1;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_c45_master #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .mdc_o(mdc_o), .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] dev, input logic [15:0] a);
    return a ^ {dev, 11'h5A3};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] opc, input logic [4:0] port,
                                            input logic [4:0] dev, input logic [1:0] ta,
                                            input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b00, opc, port, dev, ta, d};
  endfunction

  // PHY model: captures frames, answers reads for PHY_PORT
  int          pcnt = 0, frame_cnt = 0, rise_cyc = 0, mdc_bad = 0;
  logic [63:0] fr = '0, last_fr = '0;
  logic        rd_pend = 1'b0;
  logic [15:0] phy_addr = '0, rd_val = '0;

  always @(posedge mdc_o) begin
    if (pcnt > 0 && (cyc - rise_cyc) != DIV) mdc_bad++;
    rise_cyc = cyc;
    fr = {fr[62:0], mdio_line};
    if (pcnt == 45) begin
      rd_pend = (fr[11:10] == 2'b11) && (fr[9:5] == PHY_PORT);
      rd_val  = phy_val(fr[4:0], phy_addr);
    end
    if (pcnt == 63) begin
      if (fr[29:28] == 2'b00 && fr[27:23] == PHY_PORT) phy_addr = fr[15:0];
      last_fr = fr;
      frame_cnt++;
      pcnt = 0;
    end else pcnt++;
  end

  always @(negedge mdc_o) begin
    if (rst_n && (cyc - rise_cyc) != DIV/2) mdc_bad++;
    if (rd_pend && pcnt == 47) begin phy_en = 1'b1; phy_bit = 1'b0; end
    else if (rd_pend && pcnt >= 48) begin phy_en = 1'b1; phy_bit = rd_val[63-pcnt]; end
    else begin
      phy_en = 1'b0; phy_bit = 1'b1;
      if (pcnt == 0) rd_pend = 1'b0;
    end
  end

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] port,
                                           input logic [4:0] dev, input logic ex);
    return {16'h0, ex, 1'b0, op, 2'b00, port, dev};
  endfunction

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int n = 0;
    do begin brd(A_CMD, v); n++; end while (v[31] && n < 5000);
    chk(!v[31], tag, {32'h0, v}, 64'h0);
  endtask

  // issue one frame and check busy timing plus the captured frame
  task automatic run_frame(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                           input logic [63:0] exp, input string tag);
    int fc0 = frame_cnt;
    bwr(A_CMD, cmd_word(op, port, dev, 1'b1));
    addr = A_CMD; #1;
    chk(rdata[31] == 1'b1, "R4 busy on cycle after start", {63'h0, rdata[31]}, 64'h1);
    wait_idle("R4 busy clears at frame end");
    chk(frame_cnt == fc0 + 1, "R6 exactly one frame", 64'(frame_cnt - fc0), 64'h1);
    chk(last_fr == exp, tag, last_fr, exp);
  endtask

  logic [15:0] exp_paddr = '0;

  task automatic do_addr(input logic [4:0] port, input logic [4:0] dev, input logic [15:0] a);
    bwr(A_RADDR, {16'h0, a});
    run_frame(2'd3, port, dev, exp_frame(2'b00, port, dev, 2'b10, a), "R7 address frame");
    if (port == PHY_PORT) exp_paddr = a;
  endtask

  task automatic do_write(input logic [4:0] port, input logic [4:0] dev, input logic [15:0] d);
    bwr(A_WVAL, {16'h0, d});
    run_frame(2'd2, port, dev, exp_frame(2'b01, port, dev, 2'b10, d), "R7 write frame");
  endtask

  task automatic do_read(input logic [4:0] port, input logic [4:0] dev);
    logic [31:0] v;
    logic        hit = (port == PHY_PORT);
    logic [15:0] e = hit ? phy_val(dev, exp_paddr) : 16'hFFFF;
    run_frame(2'd1, port, dev, exp_frame(2'b11, port, dev, hit ? 2'b10 : 2'b11, e), "R8 read frame");
    brd(A_RVAL, v);
    chk(v == {16'h0, e}, hit ? "R8 read result" : "R10 no PHY reads 0xFFFF", {32'h0, v}, {48'h0, e});
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int fc;
    int unsigned seed = $urandom(32'h1d2c);
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    brd(A_CMD, v);   chk(v == 0, "R1 command word", {32'h0, v}, 64'h0);
    brd(A_RADDR, v); chk(v == 0, "R1 address word", {32'h0, v}, 64'h0);
    brd(A_WVAL, v);  chk(v == 0, "R1 write word", {32'h0, v}, 64'h0);
    brd(A_RVAL, v);  chk(v == 0, "R1 read word", {32'h0, v}, 64'h0);
    chk(mdc_o == 0 && mdio_oe == 0, "R1 pins idle", {62'h0, mdc_o, mdio_oe}, 64'h0);

    // R2 upper bits dropped, unmapped reads 0
    bwr(A_RADDR, 32'hABCD_1234); brd(A_RADDR, v);
    chk(v == 32'h1234, "R2 address word width", {32'h0, v}, 64'h1234);
    bwr(A_WVAL, 32'hFFFF_5A5A); brd(A_WVAL, v);
    chk(v == 32'h5A5A, "R2 write word width", {32'h0, v}, 64'h5A5A);
    brd(12'h280, v); chk(v == 0, "R2 unmapped reads 0", {32'h0, v}, 64'h0);

    // R5 op mode 0 with start is ignored
    fc = frame_cnt;
    bwr(A_CMD, cmd_word(2'd0, 5'd3, 5'd3, 1'b1));
    addr = A_CMD; #1;
    chk(rdata == 0, "R5 op mode 0 no start", {32'h0, rdata}, 64'h0);
    repeat (100) @(posedge clk);
    chk(frame_cnt == fc, "R5 op mode 0 no frame", 64'(frame_cnt), 64'(fc));

    // directed frames
    do_addr(PHY_PORT, 5'd1, 16'h0003);
    brd(A_CMD, v);
    chk(v == 32'h0000_3121, "R3 command readback", {32'h0, v}, 64'h3121);
    do_read(PHY_PORT, 5'd1);
    do_write(PHY_PORT, 5'd30, 16'hBEEF);
    do_read(5'd3, 5'd1);
    do_addr(PHY_PORT, 5'd31, 16'hFFFF);
    do_read(PHY_PORT, 5'd31);

    // R5 command write during busy is ignored
    fc = frame_cnt;
    bwr(A_CMD, cmd_word(2'd1, PHY_PORT, 5'd2, 1'b1));
    repeat (20) @(posedge clk);
    bwr(A_CMD, cmd_word(2'd2, 5'd4, 5'd7, 1'b1));
    addr = A_CMD; #1;
    chk(rdata == {1'b1, 17'b0, 2'd1, 2'b0, PHY_PORT, 5'd2}, "R5 fields held while busy",
        {32'h0, rdata}, {32'h0, 1'b1, 17'b0, 2'd1, 2'b0, PHY_PORT, 5'd2});
    wait_idle("R4 busy clears after held command");
    repeat (200) @(posedge clk);
    chk(frame_cnt == fc + 1, "R5 no second frame", 64'(frame_cnt - fc), 64'h1);
    brd(A_RVAL, v);
    chk(v[15:0] == phy_val(5'd2, exp_paddr), "R8 read result after held command",
        {48'h0, v[15:0]}, {48'h0, phy_val(5'd2, exp_paddr)});

    // random mix
    for (int i = 0; i < 16; i++) begin
      int k = $urandom % 3;
      logic [4:0] port = ($urandom % 4 == 0) ? 5'($urandom) : PHY_PORT;
      logic [4:0] dev = 5'($urandom);
      logic [15:0] d = 16'($urandom);
      if (k == 0) do_addr(port, dev, d);
      else if (k == 1) do_write(port, dev, d);
      else do_read(port, dev);
    end

    chk(mdc_bad == 0, "R9 MDC period and duty", 64'(mdc_bad), 64'h0);
    chk(mdc_o == 0, "R9 MDC idle low", {63'h0, mdc_o}, 64'h0);
    chk(mdio_oe == 0, "R11 output enable idle low", {63'h0, mdio_oe}, 64'h0);

    finished = 1'b1;
    if (seed == 0) checks = checks + 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule